// File: doc/BRIEF.md
# Core DVFS Transition Sequencer

This block moves a processor core from one operating point to another out of a fixed list of five. A request names the target frequency in MHz, and a one-cycle start strobe launches it. The sequencer then drives the regulator target codes for the core rail and the SoC rail, the PLL bypass control, the PLL multiplier field and the core post-divider field. It waits on the PLL lock input and on an internal settle timer between steps. It finishes with a one-cycle done pulse, or with a one-cycle error pulse.

The core frequency produced by a setting is 24 MHz × (multiplier / 2) / (post-divider + 1). On a speed-up the rail voltage is raised before the clock changes. On a slow-down the voltage is lowered only after the new post-divider is in place. While the PLL relocks to a new multiplier, the core runs from the bypass path. The sequencer converts each point's voltage in microvolts to a 5-bit regulator code. The SoC rail never receives a code below a configurable floor.

The analog PLL and the regulator sit outside the block. The sequencer holds the current operating point internally and replaces it only when a sequence completes.

Top module: `dvfs_sequencer`

## Requirements
- R1: After reset, the outputs hold the 198 MHz point: cur_mhz = 198, pll_mult = 66, post_div = 3, core_vtarg = 10, soc_vtarg = 18. pll_bypass, busy, done and err are all 0.
- R2: A valid request ends with these values in pll_mult and post_div. 900 MHz gives 75 and 0. 792 MHz gives 66 and 0. 528 MHz gives 88 and 1. 396 MHz gives 66 and 1. 198 MHz gives 66 and 3.
- R3: A req_mhz that is not one of the five points gives an err pulse in the cycle after start. No done pulse follows, and no output or cur_mhz changes.
- R4: A request equal to cur_mhz gives a done pulse in the cycle after start, with no output change.
- R5: On a speed-up, the regulator codes change before pll_bypass rises. On a slow-down, they change after pll_bypass falls and after post_div is written.
- R6: The PLL steps occur in this order: bypass rises, pll_mult is written, the sequencer waits for pll_locked = 1, bypass falls, then post_div is written. pll_mult never changes while bypass is 0.
- R7: The core code is 0 below 725000 µV and 31 above 1450000 µV. Between those limits it is (µV − 700000) / 25000. For the five points (1.275, 1.225, 1.175, 1.025, 0.950 V) this gives codes 23, 21, 19, 13 and 10.
- R8: soc_vtarg equals core_vtarg when that is at least SOC_MIN_CODE (default 18), and equals SOC_MIN_CODE otherwise.
- R9: After each regulator write, no PLL or divider output changes, and no done is issued, for at least SETTLE_CYC cycles. If the target core code already equals core_vtarg, the regulator step is skipped and no code changes.
- R10: If pll_locked stays 0 for LOCK_TIMEOUT cycles after the multiplier write, the sequence ends with err. pll_bypass stays 1 and cur_mhz is unchanged.
- R11: A start while busy is 1 is ignored. done and err each last exactly one cycle.
- R12: cur_mhz changes only in the cycle done is 1, and then takes the requested value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a transition to req_mhz |
| req_mhz | input | 10 | Requested core frequency in MHz |
| pll_locked | input | 1 | PLL lock indication |
| core_vtarg | output | 5 | Core rail regulator target code |
| soc_vtarg | output | 5 | SoC rail regulator target code |
| pll_bypass | output | 1 | 1 selects the oscillator bypass path for the core clock |
| pll_mult | output | 7 | PLL multiplier field |
| post_div | output | 3 | Core post-divider field (divide by value + 1) |
| cur_mhz | output | 10 | Current operating point in MHz |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on a bad request or a lock timeout |

## Verification
Some properties are checked on every cycle by assertions. These are the SoC floor, the rule that the multiplier moves only under bypass, the rule that bypass is released only after lock was seen, the quiet settle window after a regulator change, the single-cycle done and err pulses, and the rule that the operating point changes only with done. Other behaviour needs whole scenarios from the bench. That includes the final values for each point, the order of voltage and PLL steps for speed-up and slow-down, the skipped regulator step, the lock-timeout outcome and the ignored start while busy. The bench runs random sequences of valid, repeated and invalid requests and compares each one against its own table and voltage conversion.

// File: rtl/dvfs_pkg.sv
// Shared widths, the operating-point record and the voltage-to-code conversion.
// Assumes the five operating points are fixed at design time.
package dvfs_pkg;
    localparam int MHZ_W   = 10;
    localparam int MULT_W  = 7;
    localparam int PDIV_W  = 3;
    localparam int VT_W    = 5;
    localparam int UV_W    = 21;
    localparam int NUM_OPS = 5;

    localparam int UV_FLOOR = 725000;
    localparam int UV_CEIL  = 1450000;
    localparam int UV_BASE  = 700000;
    localparam int UV_STEP  = 25000;

    typedef struct packed {
        logic [MHZ_W-1:0]  mhz;
        logic [MULT_W-1:0] mult;
        logic [PDIV_W-1:0] pdiv;
        logic [UV_W-1:0]   uv;
    } op_t;

    // Operating-point table; index 0 is the reset point.
    function automatic op_t op_row(input int idx);
        op_t r;
        case (idx)
            1:       r = '{mhz: MHZ_W'(396), mult: MULT_W'(66), pdiv: PDIV_W'(1), uv: UV_W'(1025000)};
            2:       r = '{mhz: MHZ_W'(528), mult: MULT_W'(88), pdiv: PDIV_W'(1), uv: UV_W'(1175000)};
            3:       r = '{mhz: MHZ_W'(792), mult: MULT_W'(66), pdiv: PDIV_W'(0), uv: UV_W'(1225000)};
            4:       r = '{mhz: MHZ_W'(900), mult: MULT_W'(75), pdiv: PDIV_W'(0), uv: UV_W'(1275000)};
            default: r = '{mhz: MHZ_W'(198), mult: MULT_W'(66), pdiv: PDIV_W'(3), uv: UV_W'(950000)};
        endcase
        return r;
    endfunction

    // Microvolts to regulator code, saturating at both ends.
    function automatic logic [VT_W-1:0] volt_code(input logic [UV_W-1:0] uv);
        logic [UV_W-1:0] q;
        if (uv < UV_W'(UV_FLOOR)) return '0;
        if (uv > UV_W'(UV_CEIL))  return '1;
        q = (uv - UV_W'(UV_BASE)) / UV_W'(UV_STEP);
        return q[VT_W-1:0];
    endfunction
endpackage

// File: rtl/dvfs_op_lookup.sv
// Matches a requested frequency against the operating-point table.
// Assumes table frequencies are distinct; hit=0 means the request is unsupported.
module dvfs_op_lookup
    import dvfs_pkg::*;
(
    input  logic [MHZ_W-1:0] req_mhz,
    output logic             hit,
    output op_t              row
);
    logic [NUM_OPS-1:0] match;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
        localparam op_t ROW_I = op_row(i);
        assign match[i] = (req_mhz == ROW_I.mhz);
    end

    // Select the matching row; defaults to the reset point.
    always_comb begin
        row = op_row(0);
        for (int i = 0; i < NUM_OPS; i++) begin
            if (match[i]) row = op_row(i);
        end
        hit = |match;
    end
endmodule

// File: rtl/dvfs_vcode.sv
// Converts a rail voltage in microvolts to core and SoC regulator codes.
// Assumes the SoC rail has a minimum code SOC_MIN; the core rail has none.
module dvfs_vcode
    import dvfs_pkg::*;
#(
    parameter int SOC_MIN = 18
) (
    input  logic [UV_W-1:0] uv,
    output logic [VT_W-1:0] core_code,
    output logic [VT_W-1:0] soc_code
);
    // Core code from the conversion, SoC code clamped to its floor.
    always_comb begin
        core_code = volt_code(uv);
        soc_code  = (core_code < VT_W'(SOC_MIN)) ? VT_W'(SOC_MIN) : core_code;
    end
endmodule

// File: rtl/dvfs_timer.sv
// Loadable down-counter used for both the settle wait and the lock timeout.
// Assumes load has priority; zero is 1 once the count reaches 0.
module dvfs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dvfs_sequencer.sv
// Sequences a core operating-point change: regulator codes, PLL bypass,
// multiplier relock and post-divider, ordered by direction of change.
// Assumes pll_locked falls within one cycle of a multiplier change and that
// the regulator reaches its target within SETTLE_CYC cycles.
module dvfs_sequencer
    import dvfs_pkg::*;
#(
    parameter int SETTLE_CYC   = 16,
    parameter int LOCK_TIMEOUT = 64,
    parameter int SOC_MIN_CODE = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MHZ_W-1:0]  req_mhz,
    input  logic              pll_locked,
    output logic [VT_W-1:0]   core_vtarg,
    output logic [VT_W-1:0]   soc_vtarg,
    output logic              pll_bypass,
    output logic [MULT_W-1:0] pll_mult,
    output logic [PDIV_W-1:0] post_div,
    output logic [MHZ_W-1:0]  cur_mhz,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int  TMAX  = (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
    localparam int  TMR_W = $clog2(TMAX + 1);
    localparam op_t RST_OP = op_row(0);
    localparam logic [VT_W-1:0] RST_CORE = volt_code(RST_OP.uv);
    localparam logic [VT_W-1:0] RST_SOC  =
        (RST_CORE < VT_W'(SOC_MIN_CODE)) ? VT_W'(SOC_MIN_CODE) : RST_CORE;

    typedef enum logic [3:0] {
        S_IDLE, S_VWRITE, S_VWAIT, S_BYP, S_MULT, S_LOCK, S_UNBYP, S_PDIV, S_DONE
    } state_t;

    state_t            state;
    op_t               tgt;
    logic              going_up;
    logic              req_hit;
    op_t               req_row;
    logic [VT_W-1:0]   tgt_core, tgt_soc;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;

    dvfs_op_lookup u_lookup (
        .req_mhz (req_mhz),
        .hit     (req_hit),
        .row     (req_row)
    );

    dvfs_vcode #(.SOC_MIN(SOC_MIN_CODE)) u_vcode (
        .uv        (tgt.uv),
        .core_code (tgt_core),
        .soc_code  (tgt_soc)
    );

    dvfs_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    // Timer load: settle interval on a regulator write, lock window on a multiplier write.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(SETTLE_CYC - 1);
        if (state == S_VWRITE && tgt_core != core_vtarg) begin
            tmr_load = 1'b1;
        end else if (state == S_MULT) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(LOCK_TIMEOUT - 1);
        end
    end

    assign busy = (state != S_IDLE);

    // Main sequencer: walks the steps and owns every output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            tgt        <= RST_OP;
            going_up   <= 1'b0;
            core_vtarg <= RST_CORE;
            soc_vtarg  <= RST_SOC;
            pll_bypass <= 1'b0;
            pll_mult   <= RST_OP.mult;
            post_div   <= RST_OP.pdiv;
            cur_mhz    <= RST_OP.mhz;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (!req_hit) begin
                            err <= 1'b1;
                        end else if (req_mhz == cur_mhz) begin
                            done <= 1'b1;
                        end else begin
                            tgt      <= req_row;
                            going_up <= (req_mhz > cur_mhz);
                            state    <= (req_mhz > cur_mhz) ? S_VWRITE : S_BYP;
                        end
                    end
                end
                S_VWRITE: begin
                    if (tgt_core == core_vtarg) begin
                        state <= going_up ? S_BYP : S_DONE;
                    end else begin
                        core_vtarg <= tgt_core;
                        soc_vtarg  <= tgt_soc;
                        state      <= S_VWAIT;
                    end
                end
                S_VWAIT: begin
                    if (tmr_zero) state <= going_up ? S_BYP : S_DONE;
                end
                S_BYP: begin
                    pll_bypass <= 1'b1;
                    state      <= S_MULT;
                end
                S_MULT: begin
                    pll_mult <= tgt.mult;
                    state    <= S_LOCK;
                end
                S_LOCK: begin
                    if (pll_locked) begin
                        state <= S_UNBYP;
                    end else if (tmr_zero) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_UNBYP: begin
                    pll_bypass <= 1'b0;
                    state      <= S_PDIV;
                end
                S_PDIV: begin
                    post_div <= tgt.pdiv;
                    state    <= going_up ? S_DONE : S_VWRITE;
                end
                S_DONE: begin
                    done    <= 1'b1;
                    cur_mhz <= tgt.mhz;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Assertion support: cycles since the core code last changed, saturating.
    logic [TMR_W-1:0] since_v;
    logic [VT_W-1:0]  prev_core;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_core <= RST_CORE;
            since_v   <= TMR_W'(SETTLE_CYC);
        end else begin
            prev_core <= core_vtarg;
            if (core_vtarg != prev_core)          since_v <= '0;
            else if (since_v < TMR_W'(SETTLE_CYC)) since_v <= since_v + 1'b1;
        end
    end

    p_soc_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_vtarg >= VT_W'(SOC_MIN_CODE)) &&
        ((core_vtarg >= VT_W'(SOC_MIN_CODE)) ? (soc_vtarg == core_vtarg) : 1'b1));

    p_mult_under_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_mult) |-> pll_bypass);

    p_unbypass_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UNBYP) |-> $past(pll_locked));

    p_settle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_v < TMR_W'(SETTLE_CYC)) |->
            ($stable(pll_bypass) && $stable(pll_mult) && $stable(post_div) && !done));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_done_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_err_keeps_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(cur_mhz) && $stable(post_div)));

    p_timeout_bypassed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && $past(state == S_LOCK)) |-> pll_bypass);

    p_point_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_mhz) |-> done);
endmodule

// File: tb/dvfs_sequencer_test.sv
// Bench for the DVFS sequencer: PLL lock model, event-order monitor,
// random and directed requests checked against a bench-side table.
module dvfs_sequencer_test;
    localparam int SETTLE = 8;
    localparam int LOCKTO = 40;
    localparam int LDLY   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] req_mhz = '0;
    logic       pll_locked;
    logic [4:0] core_vtarg, soc_vtarg;
    logic       pll_bypass;
    logic [6:0] pll_mult;
    logic [2:0] post_div;
    logic [9:0] cur_mhz;
    logic       busy, done, err;

    int tests = 0, fails = 0, cyc = 0;
    int t_v, t_brise, t_bfall, t_mult, t_pdiv, t_done, done_len, max_done_len;
    bit never_lock = 1'b0;
    int model_cur = 198;

    always #2.5 clk = ~clk;

    dvfs_sequencer #(.SETTLE_CYC(SETTLE), .LOCK_TIMEOUT(LOCKTO), .SOC_MIN_CODE(18)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_mhz(req_mhz),
        .pll_locked(pll_locked), .core_vtarg(core_vtarg), .soc_vtarg(soc_vtarg),
        .pll_bypass(pll_bypass), .pll_mult(pll_mult), .post_div(post_div),
        .cur_mhz(cur_mhz), .busy(busy), .done(done), .err(err)
    );

    // PLL model: lock drops on a multiplier change and returns after LDLY cycles.
    logic [6:0] m_prev;
    int lcnt;
    always @(negedge clk) begin
        if (!rst_n) begin
            pll_locked <= 1'b1; m_prev <= pll_mult; lcnt <= 0;
        end else if (pll_mult != m_prev) begin
            m_prev <= pll_mult; pll_locked <= 1'b0; lcnt <= LDLY;
        end else if (lcnt > 0) begin
            lcnt <= lcnt - 1;
        end else begin
            pll_locked <= !never_lock;
        end
    end

    // Event monitor: records the cycle of each output change.
    logic [4:0] p_core; logic p_byp; logic [6:0] p_mult; logic [2:0] p_pdiv; logic p_done;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (core_vtarg != p_core) t_v = cyc;
            if (pll_bypass && !p_byp) t_brise = cyc;
            if (!pll_bypass && p_byp) t_bfall = cyc;
            if (pll_mult != p_mult) t_mult = cyc;
            if (post_div != p_pdiv) t_pdiv = cyc;
            if (done && !p_done) t_done = cyc;
            done_len = done ? done_len + 1 : 0;
            if (done_len > max_done_len) max_done_len = done_len;
        end
        p_core = core_vtarg; p_byp = pll_bypass; p_mult = pll_mult;
        p_pdiv = post_div; p_done = done;
    end

    // Watchdog: a hung run counts as a failure.
    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d cycles expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit is_valid(input int m);
        return m == 198 || m == 396 || m == 528 || m == 792 || m == 900;
    endfunction
    function automatic int e_mult(input int m);
        return (m == 900) ? 75 : (m == 528) ? 88 : 66;
    endfunction
    function automatic int e_pdiv(input int m);
        return (m >= 792) ? 0 : (m == 198) ? 3 : 1;
    endfunction
    function automatic int e_uv(input int m);
        case (m)
            900: return 1275000; 792: return 1225000; 528: return 1175000;
            396: return 1025000; default: return 950000;
        endcase
    endfunction
    function automatic int e_code(input int uv);
        if (uv < 725000) return 0;
        if (uv > 1450000) return 31;
        return (uv - 700000) / 25000;
    endfunction
    function automatic int e_soc(input int c);
        return (c < 18) ? 18 : c;
    endfunction

    bit seen_done, seen_err;
    int wait_n;

    // Issue one request, optionally a second start while busy, and wait for the end.
    task automatic issue(input int m, input int intr_m, input bit intrude);
        t_v = -1; t_brise = -1; t_bfall = -1; t_mult = -1; t_pdiv = -1; t_done = -1;
        max_done_len = 0; seen_done = 0; seen_err = 0; wait_n = 0;
        @(negedge clk); start = 1'b1; req_mhz = 10'(m);
        @(negedge clk); start = 1'b0;
        if (intrude) begin
            @(negedge clk); @(negedge clk);
            check(busy == 1'b1, "R11 busy during sequence", int'(busy), 1);
            start = 1'b1; req_mhz = 10'(intr_m);
            @(negedge clk); start = 1'b0;
        end
        while (!(done || err) && wait_n < 2000) begin
            @(negedge clk); wait_n++;
        end
        seen_done = done; seen_err = err;
        @(negedge clk); @(negedge clk);
    endtask

    // Full request with expected-value checks.
    task automatic request(input int m);
        int o_core, o_soc, o_mult, o_pdiv, o_cur, c;
        o_core = core_vtarg; o_soc = soc_vtarg; o_mult = pll_mult; o_pdiv = post_div; o_cur = cur_mhz;
        issue(m, 0, 1'b0);
        if (!is_valid(m)) begin
            check(seen_err && !seen_done && wait_n == 0, "R3 err pulse for bad request", int'(seen_err), 1);
            check(pll_mult == o_mult && post_div == o_pdiv && core_vtarg == o_core && soc_vtarg == o_soc,
                  "R3 outputs unchanged", int'(pll_mult), o_mult);
            check(cur_mhz == o_cur, "R3 cur_mhz unchanged", int'(cur_mhz), o_cur);
        end else if (m == model_cur) begin
            check(seen_done && !seen_err && wait_n == 0, "R4 immediate done", wait_n, 0);
            check(pll_mult == o_mult && post_div == o_pdiv && core_vtarg == o_core && t_brise < 0,
                  "R4 no change", int'(pll_mult), o_mult);
        end else begin
            c = e_code(e_uv(m));
            check(seen_done && !seen_err, "R2 sequence completes", int'(seen_done), 1);
            check(pll_mult == e_mult(m), "R2 multiplier", int'(pll_mult), e_mult(m));
            check(post_div == e_pdiv(m), "R2 post-divider", int'(post_div), e_pdiv(m));
            check(core_vtarg == c, "R7 core code", int'(core_vtarg), c);
            check(soc_vtarg == e_soc(c), "R8 soc code", int'(soc_vtarg), e_soc(c));
            check(cur_mhz == m, "R12 cur_mhz updated", int'(cur_mhz), m);
            check(!pll_bypass && t_brise > 0 && t_bfall > t_brise, "R6 bypass cycle", t_bfall, t_brise + 1);
            if (t_mult > 0)
                check(t_mult > t_brise && t_mult < t_bfall, "R6 mult inside bypass", t_mult, t_brise + 1);
            if (t_pdiv > 0)
                check(t_pdiv > t_bfall, "R6 post-div after bypass release", t_pdiv, t_bfall + 1);
            if (t_v > 0 && m > model_cur) begin
                check(t_v < t_brise, "R5 voltage before PLL on speed-up", t_v, t_brise - 1);
                check(t_brise - t_v >= SETTLE, "R9 settle before bypass", t_brise - t_v, SETTLE);
            end
            if (t_v > 0 && m < model_cur) begin
                check(t_v > t_bfall && t_v > t_pdiv, "R5 voltage after divider on slow-down", t_v, t_pdiv + 1);
                check(t_done - t_v >= SETTLE, "R9 settle before done", t_done - t_v, SETTLE);
            end
            check(max_done_len == 1, "R11 done one cycle", max_done_len, 1);
            model_cur = m;
        end
    endtask

    initial begin
        int picks[8];
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cur_mhz == 198 && !busy && !done && !err, "R1 reset point", int'(cur_mhz), 198);
        check(pll_mult == 66 && post_div == 3 && !pll_bypass, "R1 reset PLL fields", int'(pll_mult), 66);
        check(core_vtarg == 10 && soc_vtarg == 18, "R1 reset codes", int'(core_vtarg), 10);

        // Directed walk through every point, both directions.
        request(198);
        request(900);
        request(792);
        request(528);
        request(396);
        request(198);
        request(396);
        request(777);
        request(0);

        // R11 start while busy is ignored.
        issue(900, 198, 1'b1);
        check(seen_done && cur_mhz == 900 && pll_mult == 75, "R11 intruding start ignored", int'(cur_mhz), 900);
        model_cur = 900;
        request(198);

        // R10 lock timeout, then R9 skipped regulator step on retry.
        never_lock = 1'b1;
        issue(528, 0, 1'b0);
        check(seen_err && !seen_done, "R10 timeout raises err", int'(seen_err), 1);
        check(pll_bypass == 1'b1, "R10 bypass held after timeout", int'(pll_bypass), 1);
        check(cur_mhz == 198, "R10 cur_mhz unchanged", int'(cur_mhz), 198);
        check(core_vtarg == 19, "R10 raised code kept", int'(core_vtarg), 19);
        never_lock = 1'b0;
        repeat (2) @(negedge clk);
        issue(528, 0, 1'b0);
        check(seen_done && t_v < 0, "R9 regulator step skipped when code matches", t_v, -1);
        check(!pll_bypass && cur_mhz == 528 && post_div == 1, "R10 recovery after timeout", int'(cur_mhz), 528);
        model_cur = 528;

        // Random mix of valid, repeated and invalid requests.
        picks = '{198, 396, 528, 792, 900, 100, 1000, 0};
        for (int i = 0; i < 40; i++) begin
            int k;
            k = $urandom_range(7);
            request(k == 7 ? model_cur : picks[k]);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule